// File: doc/BRIEF.md
# Single-Level Fast Context Shadow

This block keeps one saved copy of three core processor registers: the status flags, the working accumulator and the bank selector. The core asks it to take a snapshot when it vectors to any interrupt and when it runs a subroutine call flagged as fast. When a return flagged as fast retires, the core reads the snapshot back so that it can reload all three registers in the same cycle. Both kinds of fast return use the same restore strobe. The core handles a plain return by never raising that strobe.

The copy is only one level deep. A second snapshot replaces the first without any warning, so a high-priority interrupt that lands during a low-priority handler wipes out the values the low-priority entry saved. Software has no path to read or write the saved copy. Each capture source has its own strobe line, and any one of them raises a snapshot of all three registers together.

Top module: `ctx_shadow`

## Requirements
- R1: After reset the saved copy is all zeros, so a restore before any capture returns zero on all three output buses.
- R2: A high level on any bit of `cap_req_i` at a rising clock edge stores `stat_i`, `work_i` and `bank_i` together. From the next cycle onward that snapshot is what the block holds.
- R3: While `ret_fast_i` is high, `restore_vld_o` is high in the same cycle and the three output buses show the saved copy without any register delay.
- R4: While `ret_fast_i` is low, `restore_vld_o` is low and all three output buses are zero.
- R5: A restore does not consume the saved copy. Restoring again gives the same values.
- R6: A later capture replaces an earlier one even if no restore happened between them. Only the most recent snapshot is kept.
- R7: When a capture and a restore fall in the same cycle, the outputs show the copy held before that edge, and the new snapshot is held from the next cycle.
- R8: When no capture bit is high, changes on the three input buses leave the saved copy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_req_i | input | N_CAP | Capture strobes, one per source (interrupt vectors, fast call) |
| ret_fast_i | input | 1 | Restore strobe for a fast return of either kind |
| stat_i | input | STAT_W | Current status register |
| work_i | input | WORK_W | Current working register |
| bank_i | input | BANK_W | Current bank select register |
| stat_o | output | STAT_W | Saved status value for reload |
| work_o | output | WORK_W | Saved working value for reload |
| bank_o | output | BANK_W | Saved bank select value for reload |
| restore_vld_o | output | 1 | High while the output buses carry a restore |

## Verification
The bench builds the block with its default parameters:

- Field widths 5, 8 and 4 bits, giving a 17-bit snapshot in which no two fields are the same width.
- Three capture sources.
- Gated outputs.

With unequal field widths, a swapped or shifted field changes the compared value, and with three sources each strobe line can be driven alone. The gated-output variant makes the quiet state of R4 visible at the ports. Sequences of back-to-back captures with no restore between them cover the overwrite case, and a capture and restore in the same cycle covers the ordering rule of R7.

// File: rtl/ctx_shadow_pkg.sv
package ctx_shadow_pkg;

   // Operation requested of the shadow in the current cycle
   typedef enum logic [1:0] {
      SH_IDLE = 2'b00,
      SH_CAPT = 2'b01,
      SH_REST = 2'b10,
      SH_BOTH = 2'b11
   } sh_op_e;

endpackage

// File: rtl/ctx_shadow_ctrl.sv
module ctx_shadow_ctrl
   import ctx_shadow_pkg::*;
#(
   parameter int N_CAP = 3
) (
   input  logic [N_CAP-1:0] cap_req,
   input  logic             ret_fast,
   output sh_op_e           op
);

   logic any_cap;

   // Merge every capture source; a single source needs no reduction
   generate
      if (N_CAP == 1) begin : g_one
         assign any_cap = cap_req[0];
      end else begin : g_many
         assign any_cap = |cap_req;
      end
   endgenerate

   always_comb begin
      unique case ({ret_fast, any_cap})
         2'b01:   op = SH_CAPT;
         2'b10:   op = SH_REST;
         2'b11:   op = SH_BOTH;
         default: op = SH_IDLE;
      endcase
   end

endmodule

// File: rtl/ctx_shadow_store.sv
module ctx_shadow_store #(
   parameter int W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= d;
      end
   end

endmodule

// File: rtl/ctx_shadow_outmux.sv
module ctx_shadow_outmux #(
   parameter int W        = 17,
   parameter bit GATE_OUT = 1'b1
) (
   input  logic         rest,
   input  logic [W-1:0] q,
   output logic [W-1:0] data,
   output logic         vld
);

   assign vld = rest;

   generate
      if (GATE_OUT) begin : g_gated
         // Outputs are forced quiet unless a restore is under way
         assign data = rest ? q : '0;
      end else begin : g_open
         // Outputs always show the saved copy; the consumer uses vld
         assign data = q;
      end
   endgenerate

endmodule

// File: rtl/ctx_shadow.sv
module ctx_shadow
   import ctx_shadow_pkg::*;
#(
   parameter int STAT_W   = 5,
   parameter int WORK_W   = 8,
   parameter int BANK_W   = 4,
   parameter int N_CAP    = 3,
   parameter bit GATE_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CAP-1:0]  cap_req_i,
   input  logic              ret_fast_i,
   input  logic [STAT_W-1:0] stat_i,
   input  logic [WORK_W-1:0] work_i,
   input  logic [BANK_W-1:0] bank_i,
   output logic [STAT_W-1:0] stat_o,
   output logic [WORK_W-1:0] work_o,
   output logic [BANK_W-1:0] bank_o,
   output logic              restore_vld_o
);

   localparam int TOT_W = STAT_W + WORK_W + BANK_W;

   // Elaboration-time parameter checks
   generate
      if (STAT_W < 1 || WORK_W < 1 || BANK_W < 1) begin : g_bad_width
         $error("ctx_shadow: every field width must be at least 1");
      end
      if (N_CAP < 1) begin : g_bad_ncap
         $error("ctx_shadow: at least one capture source is required");
      end
   endgenerate

   sh_op_e           op;
   logic             load;
   logic             rest;
   logic [TOT_W-1:0] snap_d;
   logic [TOT_W-1:0] shadow_q;
   logic [TOT_W-1:0] rest_data;

   ctx_shadow_ctrl #(.N_CAP(N_CAP)) u_ctrl (
      .cap_req  (cap_req_i),
      .ret_fast (ret_fast_i),
      .op       (op)
   );

   assign load   = (op == SH_CAPT) || (op == SH_BOTH);
   assign rest   = (op == SH_REST) || (op == SH_BOTH);
   assign snap_d = {stat_i, work_i, bank_i};

   ctx_shadow_store #(.W(TOT_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .d     (snap_d),
      .q     (shadow_q)
   );

   ctx_shadow_outmux #(.W(TOT_W), .GATE_OUT(GATE_OUT)) u_out (
      .rest (rest),
      .q    (shadow_q),
      .data (rest_data),
      .vld  (restore_vld_o)
   );

   assign {stat_o, work_o, bank_o} = rest_data;

endmodule

// File: rtl/ctx_shadow_chk.sv
module ctx_shadow_chk #(
   parameter int STAT_W   = 5,
   parameter int WORK_W   = 8,
   parameter int BANK_W   = 4,
   parameter int N_CAP    = 3,
   parameter bit GATE_OUT = 1'b1
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [N_CAP-1:0]                  cap_req_i,
   input logic                              ret_fast_i,
   input logic [STAT_W-1:0]                 stat_i,
   input logic [WORK_W-1:0]                 work_i,
   input logic [BANK_W-1:0]                 bank_i,
   input logic [STAT_W-1:0]                 stat_o,
   input logic [WORK_W-1:0]                 work_o,
   input logic [BANK_W-1:0]                 bank_o,
   input logic                              restore_vld_o,
   input logic [STAT_W+WORK_W+BANK_W-1:0]   shadow_q
);

   AST_CAPT_THEN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      (|cap_req_i) |=> (ret_fast_i -> ({stat_o, work_o, bank_o} ==
         $past({stat_i, work_i, bank_i})))); // R2

   AST_RESTORE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      ret_fast_i |-> (restore_vld_o && {stat_o, work_o, bank_o} == shadow_q)); // R3

   AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      !ret_fast_i |-> (!restore_vld_o &&
         (!GATE_OUT || {stat_o, work_o, bank_o} == '0))); // R4

   AST_HOLD_NO_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
      !(|cap_req_i) |=> $stable(shadow_q)); // R8

   AST_SWAP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cap_req_i) && ret_fast_i) |=>
         (shadow_q == $past({stat_i, work_i, bank_i}))); // R7

endmodule

bind ctx_shadow ctx_shadow_chk #(
   .STAT_W   (STAT_W),
   .WORK_W   (WORK_W),
   .BANK_W   (BANK_W),
   .N_CAP    (N_CAP),
   .GATE_OUT (GATE_OUT)
) u_chk (.*);

// File: tb/ctx_shadow_test.sv
module ctx_shadow_test;

   localparam int STAT_W = 5;
   localparam int WORK_W = 8;
   localparam int BANK_W = 4;
   localparam int N_CAP  = 3;
   localparam int TOT_W  = STAT_W + WORK_W + BANK_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N_CAP-1:0]  cap_req_i = '0;
   logic              ret_fast_i = 1'b0;
   logic [STAT_W-1:0] stat_i = '0;
   logic [WORK_W-1:0] work_i = '0;
   logic [BANK_W-1:0] bank_i = '0;
   logic [STAT_W-1:0] stat_o;
   logic [WORK_W-1:0] work_o;
   logic [BANK_W-1:0] bank_o;
   logic              restore_vld_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   ctx_shadow #(
      .STAT_W(STAT_W), .WORK_W(WORK_W), .BANK_W(BANK_W),
      .N_CAP(N_CAP), .GATE_OUT(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cap_req_i(cap_req_i), .ret_fast_i(ret_fast_i),
      .stat_i(stat_i), .work_i(work_i), .bank_i(bank_i),
      .stat_o(stat_o), .work_o(work_o), .bank_o(bank_o),
      .restore_vld_o(restore_vld_o)
   );

   task automatic check(input string tag, input logic [TOT_W:0] act,
                        input logic [TOT_W:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Set inputs and one capture strobe for one edge (drives at negedge)
   task automatic capture(input int src, input logic [TOT_W-1:0] v);
      @(negedge clk);
      {stat_i, work_i, bank_i} = v;
      cap_req_i = '0;
      cap_req_i[src] = 1'b1;
      @(negedge clk);
      cap_req_i = '0;
   endtask

   // Raise the restore strobe and compare {vld, data} in the same cycle
   task automatic restore_expect(input string tag, input logic [TOT_W-1:0] v);
      @(negedge clk);
      ret_fast_i = 1'b1;
      #1;
      check(tag, {restore_vld_o, stat_o, work_o, bank_o}, {1'b1, v});
      @(negedge clk);
      ret_fast_i = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      check("R4 quiet in reset state", {restore_vld_o, stat_o, work_o, bank_o}, '0);
      restore_expect("R1 zero after reset", '0);
   endtask

   task automatic t_sources();
      for (int s = 0; s < N_CAP; s++) begin
         logic [TOT_W-1:0] v;
         v = TOT_W'(17'h1_2345 + s * 17'h0_3A5C);
         capture(s, v);
         restore_expect($sformatf("R2 R3 capture via source %0d", s), v);
      end
   endtask

   task automatic t_hold();
      logic [TOT_W-1:0] v;
      v = 17'h0_A5C3;
      capture(1, v);
      @(negedge clk);
      {stat_i, work_i, bank_i} = 17'h1_FFFF;
      @(negedge clk);
      {stat_i, work_i, bank_i} = 17'h0_0001;
      @(negedge clk);
      restore_expect("R8 inputs without capture ignored", v);
      restore_expect("R5 repeat restore non-destructive", v);
   endtask

   task automatic t_nest();
      capture(1, 17'h0_1111);
      capture(0, 17'h1_E2D4);
      restore_expect("R6 nested capture overwrites", 17'h1_E2D4);
   endtask

   task automatic t_swap();
      capture(2, 17'h0_5AA5);
      @(negedge clk);
      {stat_i, work_i, bank_i} = 17'h1_0F0F;
      cap_req_i = 3'b001;
      ret_fast_i = 1'b1;
      #1;
      check("R7 same-cycle restore shows old copy",
            {restore_vld_o, stat_o, work_o, bank_o}, {1'b1, 17'h0_5AA5});
      @(negedge clk);
      cap_req_i = '0;
      ret_fast_i = 1'b0;
      restore_expect("R7 new copy held afterwards", 17'h1_0F0F);
   endtask

   task automatic t_quiet();
      @(negedge clk);
      ret_fast_i = 1'b0;
      #1;
      check("R4 outputs zero without restore",
            {restore_vld_o, stat_o, work_o, bank_o}, '0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_sources();
      t_hold();
      t_nest();
      t_swap();
      t_quiet();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule